// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block is the combinational front end of a data-processing datapath. It forms the 32-bit second operand of an instruction and the carry that the shift produces. Register values arrive already read. The block only chooses the operand form, the shift kind and the amount, and then applies them.

There are three operand forms. The first takes an 8-bit constant and rotates it right by twice a 4-bit field. The second shifts a register by a 5-bit amount held in the instruction. The third shifts a register by the least significant byte of a second register. A 2-bit code picks the shift kind: left logical, right logical, right arithmetic, or right rotate. Amounts of zero, and amounts of 32 or more, each have their own defined results and carries. In the instruction-amount form, a zero amount is given a special meaning.

Top module: `shifter_operand_unit`

## Requirements
- R1: With form_i = 0 the operand is imm8_i, zero-extended to 32 bits and rotated right by 2*rot_i. The carry-out is the last bit rotated out, which is bit (2*rot_i - 1) of the extended value. When rot_i = 0 the operand is the extended value and the carry-out equals carry_i.
- R2: When the effective amount is zero and no rotate through carry applies, operand_o equals the source value and carry_o equals carry_i.
- R3: A left logical shift (stype_i = 0) by n ≥ 1 gives carry bit (32-n) when n ≤ 32, and carry 0 when n > 32. The result is 0 for every n ≥ 32.
- R4: A right logical shift (stype_i = 1) by n ≥ 1 gives carry bit (n-1) when n ≤ 32, and carry 0 when n > 32. The result is 0 for every n ≥ 32.
- R5: A right arithmetic shift (stype_i = 2) by n ≥ 1 gives carry bit min(31, n-1). For n ≥ 32 every result bit equals bit 31 of the source.
- R6: A right rotate (stype_i = 3) by a nonzero n rotates by n mod 32 and gives carry bit ((n mod 32) - 1). When n is a nonzero multiple of 32, the value is unchanged and the carry is bit 31.
- R7: With form_i = 1, shamt_i = 0 combined with stype_i = 1 or stype_i = 2 acts as a shift by 32.
- R8: With form_i = 1, shamt_i = 0 combined with stype_i = 3 rotates through carry. The result is {carry_i, rm_val_i[31:1]} and the carry-out is rm_val_i[0].
- R9: With form_i = 2 or 3 the amount is rs_val_i[7:0] and bits 31:8 are ignored. An amount of 0 is not reinterpreted and passes the value and carry through unchanged.
- R10: The form encoding is 0 = rotated constant, 1 = instruction amount, 2 or 3 = register amount. The outputs follow the inputs combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| form_i | input | 2 | Operand form select |
| rot_i | input | 4 | Constant rotate field (rotation is twice this value) |
| imm8_i | input | 8 | 8-bit constant |
| shamt_i | input | 5 | Shift amount from the instruction |
| stype_i | input | 2 | Shift kind: 0 left, 1 right logical, 2 right arithmetic, 3 rotate |
| rm_val_i | input | 32 | Value to be shifted |
| rs_val_i | input | 32 | Register that holds the shift amount |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Both results are combinational, so operand_o and carry_o are due in the same cycle that the inputs change, with zero clock cycles of latency. The bench changes the inputs 1 ns after each rising edge. It compares both outputs with a behavioural model 2 ns later, well before the next edge, so one vector is checked on every clock. The model steps the shift one bit at a time and keeps the last bit shifted out. It therefore reaches the boundary carries at 0, 32, more than 32, and multiples of 32 by a different route than the RTL takes.

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit (
  input  logic [1:0]  form_i,
  input  logic [3:0]  rot_i,
  input  logic [7:0]  imm8_i,
  input  logic [4:0]  shamt_i,
  input  logic [1:0]  stype_i,
  input  logic [31:0] rm_val_i,
  input  logic [31:0] rs_val_i,
  input  logic        carry_i,
  output logic [31:0] operand_o,
  output logic        carry_o
);
  localparam logic [1:0] K_LSL = 2'd0;
  localparam logic [1:0] K_LSR = 2'd1;
  localparam logic [1:0] K_ASR = 2'd2;
  localparam logic [1:0] K_ROR = 2'd3;

  logic [31:0] src;
  logic [7:0]  amt;
  logic [1:0]  kind;
  logic        rrx;
  logic        big;
  logic        is32;
  logic [4:0]  a5;
  logic        unused_rs_hi;

  assign unused_rs_hi = ^rs_val_i[31:8];

  always_comb begin
    src  = rm_val_i;
    kind = stype_i;
    rrx  = 1'b0;
    amt  = rs_val_i[7:0];
    case (form_i)
      2'd0: begin
        src  = {24'd0, imm8_i};
        kind = K_ROR;
        amt  = {3'd0, rot_i, 1'b0};
      end
      2'd1: begin
        amt = {3'd0, shamt_i};
        if (shamt_i == 5'd0) begin
          if (stype_i == K_LSR || stype_i == K_ASR) amt = 8'd32;
          if (stype_i == K_ROR) rrx = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign big  = |amt[7:5];
  assign is32 = (amt == 8'd32);
  assign a5   = amt[4:0];

  always_comb begin
    operand_o = src;
    carry_o   = carry_i;
    if (rrx) begin
      operand_o = {carry_i, src[31:1]};
      carry_o   = src[0];
    end else if (amt != 8'd0) begin
      case (kind)
        K_LSL: begin
          if (!big) begin
            operand_o = src << a5;
            carry_o   = src[5'(6'd32 - {1'b0, a5})];
          end else begin
            operand_o = 32'd0;
            carry_o   = is32 ? src[0] : 1'b0;
          end
        end
        K_LSR: begin
          if (!big) begin
            operand_o = src >> a5;
            carry_o   = src[a5 - 5'd1];
          end else begin
            operand_o = 32'd0;
            carry_o   = is32 ? src[31] : 1'b0;
          end
        end
        K_ASR: begin
          if (!big) begin
            operand_o = $unsigned($signed(src) >>> a5);
            carry_o   = src[a5 - 5'd1];
          end else begin
            operand_o = {32{src[31]}};
            carry_o   = src[31];
          end
        end
        default: begin
          if (a5 == 5'd0) begin
            operand_o = src;
            carry_o   = src[31];
          end else begin
            operand_o = (src >> a5) | (src << (6'd32 - {1'b0, a5}));
            carry_o   = src[a5 - 5'd1];
          end
        end
      endcase
    end
  end

  always_comb begin
    if (form_i == 2'd0 && rot_i == 4'd0) begin
      AST_CONST_NO_ROT: assert (operand_o == {24'd0, imm8_i} && carry_o == carry_i); // R1
    end
    if (form_i == 2'd1 && shamt_i == 5'd0 && stype_i == K_ROR) begin
      AST_RRX_ENTRY: assert (operand_o == {carry_i, rm_val_i[31:1]} && carry_o == rm_val_i[0]); // R8
    end
    if (form_i[1] && stype_i == K_LSL && rs_val_i[7:0] >= 8'd32) begin
      AST_LSL_CLEARED: assert (operand_o == 32'd0); // R3
    end
    if (form_i[1] && stype_i == K_ASR && rs_val_i[7:0] >= 8'd32) begin
      AST_ASR_SIGN_FILL: assert (operand_o == {32{rm_val_i[31]}} && carry_o == rm_val_i[31]); // R5
    end
    if (form_i[1] && rs_val_i[7:0] == 8'd0) begin
      AST_REG_ZERO_PASS: assert (operand_o == rm_val_i && carry_o == carry_i); // R9
    end
    if (form_i == 2'd1 && shamt_i == 5'd0 && stype_i == K_LSR) begin
      AST_LSR_AS_32: assert (operand_o == 32'd0 && carry_o == rm_val_i[31]); // R7
    end
  end
endmodule

// File: tb/shifter_operand_unit_tb_top.sv
module shifter_operand_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  form_i = '0;
  logic [3:0]  rot_i = '0;
  logic [7:0]  imm8_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [1:0]  stype_i = '0;
  logic [31:0] rm_val_i = '0;
  logic [31:0] rs_val_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] operand_o;
  logic        carry_o;

  int vecs = 0;
  int bad = 0;
  bit done = 0;

  shifter_operand_unit dut_i (
    .form_i(form_i), .rot_i(rot_i), .imm8_i(imm8_i), .shamt_i(shamt_i),
    .stype_i(stype_i), .rm_val_i(rm_val_i), .rs_val_i(rs_val_i),
    .carry_i(carry_i), .operand_o(operand_o), .carry_o(carry_o)
  );

  function automatic logic [32:0] model(input logic [1:0] f, input logic [3:0] r,
      input logic [7:0] k, input logic [4:0] sa, input logic [1:0] st,
      input logic [31:0] a, input logic [31:0] b, input logic ci);
    logic [31:0] v;
    int n;
    int knd;
    logic c;
    logic outbit;
    v = a; knd = st; c = ci;
    if (f == 2'd0) begin
      v = {24'd0, k}; knd = 3; n = 2 * r;
    end else if (f == 2'd1) begin
      n = sa;
      if (n == 0 && (knd == 1 || knd == 2)) n = 32;
      if (n == 0 && knd == 3) return {a[0], ci, a[31:1]};
    end else begin
      n = b[7:0];
    end
    for (int i = 0; i < n; i++) begin
      case (knd)
        0: begin outbit = v[31]; v = {v[30:0], 1'b0}; end
        1: begin outbit = v[0]; v = {1'b0, v[31:1]}; end
        2: begin outbit = v[0]; v = {v[31], v[31:1]}; end
        default: begin outbit = v[0]; v = {v[0], v[31:1]}; end
      endcase
      c = outbit;
    end
    return {c, v};
  endfunction

  task automatic apply(input string tag, input logic [1:0] f, input logic [3:0] r,
      input logic [7:0] k, input logic [4:0] sa, input logic [1:0] st,
      input logic [31:0] a, input logic [31:0] b, input logic ci);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    form_i = f; rot_i = r; imm8_i = k; shamt_i = sa; stype_i = st;
    rm_val_i = a; rs_val_i = b; carry_i = ci;
    exp = model(f, r, k, sa, st, a, b, ci);
    #2;
    vecs++;
    if ({carry_o, operand_o} !== exp) begin
      bad++;
      $display("FAIL %s: actual c=%0b op=%08h expected c=%0b op=%08h",
               tag, carry_o, operand_o, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    apply("R2 idle zero", 2'd0, 4'd0, 8'd0, 5'd0, 2'd0, 32'd0, 32'd0, 1'b1);
    apply("R1 rot0", 2'd0, 4'd0, 8'hA5, 5'd0, 2'd0, 32'hFFFF_FFFF, 0, 1'b1);
    apply("R1 rot1", 2'd0, 4'd1, 8'h03, 5'd0, 2'd0, 0, 0, 1'b0);
    apply("R1 rot4", 2'd0, 4'd4, 8'hFF, 5'd0, 2'd0, 0, 0, 1'b0);
    apply("R1 rot15", 2'd0, 4'd15, 8'h81, 5'd0, 2'd0, 0, 0, 1'b0);
    apply("R2 lsl imm 0", 2'd1, 4'd0, 8'd0, 5'd0, 2'd0, 32'h8000_0001, 0, 1'b1);
    apply("R3 lsl 1", 2'd1, 4'd0, 8'd0, 5'd1, 2'd0, 32'h8000_0001, 0, 1'b0);
    apply("R3 lsl 31", 2'd1, 4'd0, 8'd0, 5'd31, 2'd0, 32'h0000_0003, 0, 1'b0);
    apply("R3 lsl reg 32", 2'd2, 4'd0, 8'd0, 5'd0, 2'd0, 32'h0000_0001, 32'd32, 1'b0);
    apply("R3 lsl reg 33", 2'd2, 4'd0, 8'd0, 5'd0, 2'd0, 32'hFFFF_FFFF, 32'd33, 1'b1);
    apply("R4 lsr 5", 2'd1, 4'd0, 8'd0, 5'd5, 2'd1, 32'hF000_0010, 0, 1'b0);
    apply("R4 lsr reg 32", 2'd2, 4'd0, 8'd0, 5'd0, 2'd1, 32'h8000_0000, 32'd32, 1'b0);
    apply("R4 lsr reg 200", 2'd2, 4'd0, 8'd0, 5'd0, 2'd1, 32'hFFFF_FFFF, 32'd200, 1'b1);
    apply("R5 asr 4 neg", 2'd1, 4'd0, 8'd0, 5'd4, 2'd2, 32'h8000_0008, 0, 1'b0);
    apply("R5 asr reg 40", 2'd2, 4'd0, 8'd0, 5'd0, 2'd2, 32'h8000_0000, 32'd40, 1'b0);
    apply("R5 asr reg 255 pos", 2'd2, 4'd0, 8'd0, 5'd0, 2'd2, 32'h7FFF_FFFF, 32'd255, 1'b1);
    apply("R6 ror 8", 2'd1, 4'd0, 8'd0, 5'd8, 2'd3, 32'h1234_5680, 0, 1'b0);
    apply("R6 ror reg 32", 2'd2, 4'd0, 8'd0, 5'd0, 2'd3, 32'h8000_0000, 32'd32, 1'b0);
    apply("R6 ror reg 64 b31=0", 2'd2, 4'd0, 8'd0, 5'd0, 2'd3, 32'h0000_0001, 32'd64, 1'b1);
    apply("R6 ror reg 33", 2'd2, 4'd0, 8'd0, 5'd0, 2'd3, 32'h0000_0001, 32'd33, 1'b0);
    apply("R7 lsr imm 0", 2'd1, 4'd0, 8'd0, 5'd0, 2'd1, 32'h8000_0001, 0, 1'b0);
    apply("R7 asr imm 0", 2'd1, 4'd0, 8'd0, 5'd0, 2'd2, 32'h8000_0000, 0, 1'b0);
    apply("R8 rrx c1", 2'd1, 4'd0, 8'd0, 5'd0, 2'd3, 32'h0000_0003, 0, 1'b1);
    apply("R8 rrx c0", 2'd1, 4'd0, 8'd0, 5'd0, 2'd3, 32'hFFFF_FFFE, 0, 1'b0);
    apply("R9 reg 0x100", 2'd2, 4'd0, 8'd0, 5'd0, 2'd1, 32'hDEAD_BEEF, 32'h0000_0100, 1'b1);
    apply("R9 reg 0 ror", 2'd2, 4'd0, 8'd0, 5'd0, 2'd3, 32'hDEAD_BEEF, 32'hFF00_0000, 1'b0);
    apply("R9 reg hi ignored", 2'd2, 4'd0, 8'd0, 5'd0, 2'd0, 32'h0000_00FF, 32'hABCD_0004, 1'b0);
    apply("R10 form3 lsr", 2'd3, 4'd0, 8'd0, 5'd0, 2'd1, 32'h8000_0000, 32'd31, 1'b0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rb;
      rb = $urandom;
      if (i % 3 == 0) rb = {rb[31:8], 2'b00, rb[5:0]};
      apply("R10 random", 2'($urandom), 4'($urandom), 8'($urandom), 5'($urandom),
            2'($urandom), $urandom, rb, 1'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule